// File: doc/BRIEF.md
# Flash Write-Protect and Wait Controller

This block sits beside an on-chip flash array and decides which parts of the array may be written. It also tells the bus when a read needs one extra wait cycle. Software sets it up through a small register write bus. The settings are a master enable, a self-erase mode select, a two-step unlock bit, a secondary protect bit and a boot-region wait bit. From these the block drives one write-enable output for each of three flash regions:

- the boot data region (blocks A and B);
- user blocks 0 and 1;
- all remaining user blocks.

For each flash access, the bus supplies a region code and a read/write flag. The block answers with a wait request for that access. It also raises a one-cycle violation pulse after any write that hit a protected region. The unlock bit only takes a 1 when the previous write to its register carried a 0, so a single stray write cannot open the array.

There are two registers. CTRL sits at address 0: bit 0 is the master enable, bit 1 is self-erase mode, and bit 2 is the secondary protect. CFG sits at address 1: bit 0 is the unlock bit and bit 1 is the boot wait. Region codes on `acc_region` are 0 for boot A/B, 1 for user 0/1, 2 for the other user blocks and 3 for internal RAM.

Top module: `flash_guard`

## Requirements
- R1: After reset every control bit is 0. All write enables, `ew_mode`, `viol` and the unlock arming are 0.
- R2: `ew_mode` is 1 exactly when the master enable (CTRL bit 0) and self-erase mode (CTRL bit 1) are both 1.
- R3: A CFG write with bit 0 = 1 sets the unlock bit only if the most recent earlier CFG write had bit 0 = 0. Otherwise the unlock bit keeps its value. After reset a fresh 0 write is needed.
- R4: Any single CFG write with bit 0 = 0 clears the unlock bit.
- R5: While the master enable is 0, `we_boot`, `we_user01` and `we_other` are all 0.
- R6: `we_boot` is 1 whenever the master enable is 1, whatever the unlock and protect bits hold.
- R7: `we_user01` is 1 only when the master enable, the unlock bit and the secondary protect (CTRL bit 2) are all 1.
- R8: `we_other` is 1 when the master enable and the unlock bit are 1, whatever the secondary protect holds.
- R9: For a read access (`acc_valid`=1, `acc_write`=0), `wait_req` follows the region:
  - boot region (code 0): `wait_req` is `boot_wait | global_wait`;
  - all other regions: `wait_req` is `global_wait` alone.
  `wait_req` is 0 when there is no read.
- R10: A write access to a flash region whose enable is 0 makes `viol` 1 in the next cycle only. Writes to enabled regions and to RAM (code 3) never raise it.
- R11: Register writes to addresses other than 0 and 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| acc_valid | input | 1 | Flash/RAM access in this cycle |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_region | input | 2 | Region code of the access |
| global_wait | input | 1 | System-wide wait setting |
| we_boot | output | 1 | Write enable, boot blocks A/B |
| we_user01 | output | 1 | Write enable, user blocks 0/1 |
| we_other | output | 1 | Write enable, other user blocks |
| ew_mode | output | 1 | Effective self-erase mode |
| wait_req | output | 1 | Insert one wait cycle for this access |
| viol | output | 1 | One-cycle pulse after a blocked write |

## Verification
The main hidden state is the unlock arming flag, and it cannot be seen directly. If it is wrong, `we_other` and `we_user01` show it one cycle after the following CFG write of 1: they either open too early or fail to open. A wrong stored control bit shows in the same cycle as a wrong write enable, `ew_mode` or `wait_req`. A wrong violation flop shows as a pulse one cycle late, or as a pulse that stays high. The bench keeps a reference model of the registers and compares every output after every cycle of mixed random and directed traffic.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    RG_BOOT   = 2'd0,
    RG_USER01 = 2'd1,
    RG_OTHER  = 2'd2,
    RG_RAM    = 2'd3
  } region_e;

  typedef struct packed {
    logic en;    // master enable
    logic ers;   // self-erase mode select
    logic prot;  // secondary protect
    logic unl;   // unlock
    logic bw;    // boot-region wait
  } ctl_s;
endpackage

// File: rtl/fg_rst_sync.sv
module fg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/fg_regs.sv
module fg_regs
  import fg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0,
  parameter int CFG_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_s              ctl
);
  localparam int B_EN   = 0;
  localparam int B_ERS  = 1;
  localparam int B_PROT = 2;
  localparam int B_UNL  = 0;
  localparam int B_BW   = 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);

  ctl_s ctl_q, ctl_d;
  logic armed_q, armed_d;
  logic hit_ctrl, hit_cfg;

  assign hit_ctrl = wr_en && (wr_addr == A_CTRL);
  assign hit_cfg  = wr_en && (wr_addr == A_CFG);

  always_comb begin
    ctl_d   = ctl_q;
    armed_d = armed_q;
    if (hit_ctrl) begin
      ctl_d.en   = wr_data[B_EN];
      ctl_d.ers  = wr_data[B_ERS];
      ctl_d.prot = wr_data[B_PROT];
    end
    if (hit_cfg) begin
      ctl_d.bw = wr_data[B_BW];
      armed_d  = ~wr_data[B_UNL];
      if (!wr_data[B_UNL]) ctl_d.unl = 1'b0;
      else if (armed_q)    ctl_d.unl = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else if (hit_ctrl || hit_cfg) begin
      ctl_q   <= ctl_d;
      armed_q <= armed_d;
    end
  end

  assign ctl = ctl_q;

  AST_UNLOCK_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cfg && wr_data[B_UNL] && !armed_q && !ctl_q.unl) |=> !ctl_q.unl); // R3
  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cfg && !wr_data[B_UNL]) |=> !ctl_q.unl); // R4
  AST_OTHER_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_ctrl && !hit_cfg) |=> $stable(ctl_q)); // R11
endmodule

// File: rtl/fg_decode.sv
module fg_decode
  import fg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_s       ctl,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic [1:0] acc_region,
  input  logic       global_wait,
  output logic       we_boot,
  output logic       we_user01,
  output logic       we_other,
  output logic       ew_mode,
  output logic       wait_req,
  output logic       viol
);
  region_e rg;
  logic    region_ok;
  logic    viol_d, viol_q;

  assign rg = region_e'(acc_region);

  always_comb begin
    we_boot   = ctl.en;
    we_user01 = ctl.en & ctl.unl & ctl.prot;
    we_other  = ctl.en & ctl.unl;
    ew_mode   = ctl.en & ctl.ers;
    unique case (rg)
      RG_BOOT:   region_ok = we_boot;
      RG_USER01: region_ok = we_user01;
      RG_OTHER:  region_ok = we_other;
      default:   region_ok = 1'b1;
    endcase
    wait_req = 1'b0;
    if (acc_valid && !acc_write)
      wait_req = (rg == RG_BOOT) ? (ctl.bw | global_wait) : global_wait;
    viol_d = acc_valid & acc_write & ~region_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign viol = viol_q;

  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |-> !(we_boot | we_user01 | we_other)); // R5
  AST_USER01_IMPLIES_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    we_user01 |-> we_other); // R7
  AST_BOOT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && rg == RG_BOOT && ctl.bw) |-> wait_req); // R9
  AST_VIOL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(acc_valid && acc_write && rg != RG_RAM)); // R10
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0,
  parameter int CFG_ADDR  = 1,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_region,
  input  logic              global_wait,
  output logic              we_boot,
  output logic              we_user01,
  output logic              we_other,
  output logic              ew_mode,
  output logic              wait_req,
  output logic              viol
);
  logic rst_n_s;
  ctl_s ctl;

  fg_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  fg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctl(ctl)
  );

  fg_decode u_dec (
    .clk(clk), .rst_n(rst_n_s), .ctl(ctl),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_region(acc_region),
    .global_wait(global_wait),
    .we_boot(we_boot), .we_user01(we_user01), .we_other(we_other),
    .ew_mode(ew_mode), .wait_req(wait_req), .viol(viol)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_s |-> !(we_boot | we_user01 | we_other | ew_mode | viol)); // R1
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [1:0] acc_region = '0;
  logic       global_wait = 1'b0;
  logic       we_boot, we_user01, we_other, ew_mode, wait_req, viol;

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  logic m_en, m_ers, m_prot, m_unl, m_armed, m_bw;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_region(acc_region),
    .global_wait(global_wait), .we_boot(we_boot), .we_user01(we_user01),
    .we_other(we_other), .ew_mode(ew_mode), .wait_req(wait_req), .viol(viol)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic f_region_ok(input logic [1:0] r);
    case (r)
      2'd0: return m_en;
      2'd1: return m_en & m_unl & m_prot;
      2'd2: return m_en & m_unl;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic f_wait(input logic v, input logic w, input logic [1:0] r, input logic g);
    if (!v || w) return 1'b0;
    return (r == 2'd0) ? (m_bw | g) : g;
  endfunction

  task automatic model_reset();
    m_en = 0; m_ers = 0; m_prot = 0; m_unl = 0; m_armed = 0; m_bw = 0;
  endtask

  task automatic model_write(input logic e, input logic [3:0] a, input logic [7:0] d);
    if (!e) return;
    if (a == 4'd0) begin
      m_en = d[0]; m_ers = d[1]; m_prot = d[2];
    end else if (a == 4'd1) begin
      m_bw = d[1];
      if (!d[0]) m_unl = 1'b0;
      else if (m_armed) m_unl = 1'b1;
      m_armed = ~d[0];
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, clock, check viol.
  task automatic step(input logic e, input logic [3:0] a, input logic [7:0] d,
                      input logic v, input logic w, input logic [1:0] r, input logic g);
    logic exp_viol;
    @(negedge clk);
    wr_en = e; wr_addr = a; wr_data = d;
    acc_valid = v; acc_write = w; acc_region = r; global_wait = g;
    #1;
    chk("R5/R6 we_boot",  we_boot,   m_en);
    chk("R7 we_user01",   we_user01, m_en & m_unl & m_prot);
    chk("R8 we_other",    we_other,  m_en & m_unl);
    chk("R2 ew_mode",     ew_mode,   m_en & m_ers);
    chk("R9 wait_req",    wait_req,  f_wait(v, w, r, g));
    exp_viol = v & w & ~f_region_ok(r);
    @(posedge clk);
    model_write(e, a, d);
    #1;
    chk("R10 viol", viol, exp_viol);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 4'd0, 8'd0, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 we_boot",   we_boot,   1'b0);
    chk("R1 we_user01", we_user01, 1'b0);
    chk("R1 we_other",  we_other,  1'b0);
    chk("R1 ew_mode",   ew_mode,   1'b0);
    chk("R1 viol",      viol,      1'b0);

    // R5: writes blocked while master off; violation on boot write
    step(1'b0, 4'd0, 8'd0, 1'b1, 1'b1, 2'd0, 1'b0);
    wr(4'd0, 8'h07);                 // enable, erase mode, protect
    chk("R6 we_boot on", we_boot, 1'b1);
    // R3: 1 right after reset without a 0 must not unlock
    wr(4'd1, 8'h01);
    chk("R3 no unlock without 0", we_other, 1'b0);
    wr(4'd1, 8'h01);
    chk("R3 repeated 1 still locked", we_other, 1'b0);
    wr(4'd1, 8'h00);
    wr(4'd1, 8'h01);
    chk("R3 unlock after 0 then 1", we_other, 1'b1);
    chk("R7 user01 both bits", we_user01, 1'b1);
    // R11: other addresses ignored
    wr(4'd2, 8'h00);
    wr(4'd15, 8'h00);
    chk("R11 ctrl kept", ew_mode, 1'b1);
    chk("R11 unlock kept", we_other, 1'b1);
    // R4: single 0 clears
    wr(4'd1, 8'h00);
    chk("R4 cleared", we_other, 1'b0);
    // R3: a 0, then a CFG 1 after an intervening CTRL write still unlocks
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h01);
    chk("R3 unlock via last CFG write", we_other, 1'b1);
    chk("R7 user01 needs protect", we_user01, 1'b0);
    // R10: blocked user01 write, allowed other write, RAM write
    step(1'b0, 4'd0, 8'd0, 1'b1, 1'b1, 2'd1, 1'b0);
    step(1'b0, 4'd0, 8'd0, 1'b1, 1'b1, 2'd2, 1'b0);
    step(1'b0, 4'd0, 8'd0, 1'b1, 1'b1, 2'd3, 1'b0);
    idle();
    // R9: boot wait on reads
    wr(4'd1, 8'h03);
    step(1'b0, 4'd0, 8'd0, 1'b1, 1'b0, 2'd0, 1'b0);
    step(1'b0, 4'd0, 8'd0, 1'b1, 1'b0, 2'd1, 1'b0);
    step(1'b0, 4'd0, 8'd0, 1'b1, 1'b0, 2'd3, 1'b1);
    // R2/R5: master off masks everything
    wr(4'd0, 8'h06);
    chk("R5 all off", we_boot | we_user01 | we_other, 1'b0);
    chk("R2 mode masked", ew_mode, 1'b0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      logic [3:0] a;
      d = 8'($urandom);
      a = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 2);
      step(($urandom % 3) != 0, a, d, 1'($urandom), 1'($urandom),
           2'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule